// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This unit multiplies two 32-bit integers and returns the complete 64-bit product. It is meant to sit beside a processor's integer pipeline. A one-cycle start pulse launches an operation. The operation carries its own choice of two's-complement or unsigned interpretation, and its own choice of whether the product is simply returned or summed into a 64-bit running accumulator for multiply-accumulate loops.

The pipeline depth is fixed when the block is built. A short build finishes in 2 cycles and a long build in 5. The long build gives the multiplier extra register stages, which retiming can spread through the multiplier to reach a higher clock rate. While an operation is in flight, a busy flag is raised. A start that arrives during that time is dropped and reported on an error strobe. A separate clear input zeroes the accumulator. Zero and negative flags describe each delivered result.

Top module: `mac_unit`

## Requirements
- R1: With `signed_i`=0 both operands are read as unsigned and `result_o` carries their full 64-bit product, e.g. 0xFFFFFFFF x 0xFFFFFFFF = 0xFFFFFFFE00000001.
- R2: With `signed_i`=1 both operands are read as two's complement and `result_o` is the 64-bit two's-complement product, e.g. 0xFFFFFFFF x 0xFFFFFFFF = 1 and 0x80000000 x 0xFFFFFFFF = 0x0000000080000000.
- R3: `done_o` is high for exactly one cycle, and that cycle is the N-th cycle after the cycle in which a start was accepted. N is 2 when `LONG_LAT`=0 and 5 when `LONG_LAT`=1. `result_o` updates in that cycle and then holds until the next `done_o`.
- R4: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle inclusive, and is low otherwise. A start is accepted when `start_i` is high and `busy_o` is low.
- R5: A start while `busy_o` is high is ignored. `err_o` is high for the one following cycle. The in-flight result, the accumulator and the number of `done_o` pulses are unchanged.
- R6: An operation with `acc_en_i`=1 adds its product to the accumulator modulo 2^64, without saturation. In its `done_o` cycle, both `acc_o` and `result_o` show the new accumulator value.
- R7: An operation with `acc_en_i`=0 leaves `acc_o` unchanged and returns the plain product on `result_o`.
- R8: `clear_i` high for a cycle in which no accumulating operation finishes makes `acc_o` zero in the next cycle.
- R9: If `clear_i` is high in the cycle just before the `done_o` of an accumulating operation, the clear wins over the add. The accumulator and `result_o` become that operation's product alone.
- R10: In each `done_o` cycle, `zero_o` is 1 exactly when `result_o` is zero and `neg_o` equals bit 63 of `result_o`. Both flags hold until the next `done_o`.
- R11: After reset, `busy_o`, `done_o`, `err_o`, `zero_o` and `neg_o` are 0, and `result_o` and `acc_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse for one operation |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| acc_en_i | input | 1 | 1 = add product into the accumulator |
| clear_i | input | 1 | Zero the accumulator |
| op_a_i | input | 32 | Multiplicand |
| op_b_i | input | 32 | Multiplier |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | Result-valid pulse |
| err_o | output | 1 | A start was dropped in the previous cycle |
| result_o | output | 64 | Product, or new accumulator value in accumulate mode |
| acc_o | output | 64 | Accumulator contents |
| zero_o | output | 1 | Last result was zero |
| neg_o | output | 1 | Last result had bit 63 set |

## Verification
Two events can meet at the same clock edge. The first is a clear request against the write-back of an accumulating operation. The second is a fresh start against an operation that is still busy. The bench raises `clear_i` in exactly the cycle before the `done_o` of an accumulating multiply, after the accumulator already holds a nonzero value, and expects the accumulator to equal that lone product rather than zero or the sum. It also pulses `start_i` with different operands one cycle after an accepted start, and expects an error strobe, a single `done_o`, and the first operation's product.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic {
    SIGN_OFF = 1'b0,
    SIGN_ON  = 1'b1
  } sign_mode_e;

  // Pipeline depth for the two build options.
  function automatic int unsigned pick_latency(bit long_lat);
    return long_lat ? 5 : 2;
  endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  input  logic              sgn,
  output logic [2*OP_W-1:0] prod
);
  localparam int RES_W = 2 * OP_W;

  logic signed [RES_W-1:0] a_x;
  logic signed [RES_W-1:0] b_x;

  // Extension to result width; the low RES_W bits of the product are exact.
  always_comb begin
    a_x  = {{OP_W{sgn & a[OP_W-1]}}, a};
    b_x  = {{OP_W{sgn & b[OP_W-1]}}, b};
    prod = a_x * b_x;
  end
endmodule

// File: rtl/mac_stage.sv
module mac_stage
  import mac_pkg::*;
#(
  parameter int OP_W = 32,
  parameter int LAT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  sign_mode_e        sgn,
  input  logic              acc_en,
  output logic              any_vld,
  output logic              fin_vld,
  output logic              fin_acc,
  output logic [2*OP_W-1:0] fin_prod
);
  localparam int RES_W = 2 * OP_W;
  localparam int NST   = LAT - 1;   // stages held here; the last lives in mac_acc

  logic [OP_W-1:0]  a_q, b_q;
  sign_mode_e       sgn_q;
  logic [NST-1:0]   vld;
  logic [NST-1:0]   accf;
  logic [RES_W-1:0] p0;

  always_ff @(posedge clk) begin
    if (accept) begin
      a_q     <= op_a;
      b_q     <= op_b;
      sgn_q   <= sgn;
      accf[0] <= acc_en;
    end
    for (int i = 1; i < NST; i++) accf[i] <= accf[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      vld[0] <= accept;
      for (int i = 1; i < NST; i++) vld[i] <= vld[i-1];
    end
  end

  mac_mult #(.OP_W(OP_W)) mult_i (
    .a    (a_q),
    .b    (b_q),
    .sgn  (sgn_q == SIGN_ON),
    .prod (p0)
  );

  generate
    if (LAT > 2) begin : g_deep
      logic [RES_W-1:0] pd [LAT-2];
      always_ff @(posedge clk) begin
        pd[0] <= p0;
        for (int j = 1; j < LAT - 2; j++) pd[j] <= pd[j-1];
      end
      assign fin_prod = pd[LAT-3];
    end else begin : g_short
      assign fin_prod = p0;
    end
  endgenerate

  assign any_vld = |vld;
  assign fin_vld = vld[NST-1];
  assign fin_acc = accf[NST-1];
endmodule

// File: rtl/mac_acc.sv
module mac_acc #(
  parameter int RES_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fin_vld,
  input  logic             fin_acc,
  input  logic             clear,
  input  logic [RES_W-1:0] fin_prod,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic [RES_W-1:0] acc,
  output logic             zero,
  output logic             neg
);
  logic [RES_W-1:0] acc_nxt;
  logic [RES_W-1:0] res_nxt;
  logic             add_now;

  always_comb begin
    add_now = fin_vld & fin_acc;
    acc_nxt = acc;
    if (clear)        acc_nxt = add_now ? fin_prod : '0;
    else if (add_now) acc_nxt = acc + fin_prod;
    res_nxt = fin_acc ? acc_nxt : fin_prod;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      result <= '0;
      acc    <= '0;
      zero   <= 1'b0;
      neg    <= 1'b0;
    end else begin
      done <= fin_vld;
      acc  <= acc_nxt;
      if (fin_vld) begin
        result <= res_nxt;
        zero   <= (res_nxt == '0);
        neg    <= res_nxt[RES_W-1];
      end
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W     = 32,
  parameter bit LONG_LAT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              signed_i,
  input  logic              acc_en_i,
  input  logic              clear_i,
  input  logic [OP_W-1:0]   op_a_i,
  input  logic [OP_W-1:0]   op_b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2*OP_W-1:0] result_o,
  output logic [2*OP_W-1:0] acc_o,
  output logic              zero_o,
  output logic              neg_o
);
  localparam int LAT   = int'(pick_latency(LONG_LAT));
  localparam int RES_W = 2 * OP_W;

  logic             accept;
  logic             any_vld;
  logic             fin_vld;
  logic             fin_acc;
  logic [RES_W-1:0] fin_prod;

  assign busy_o = any_vld | done_o;
  assign accept = start_i & ~busy_o;

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= start_i & busy_o;
  end

  mac_stage #(.OP_W(OP_W), .LAT(LAT)) stage_i (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .op_a     (op_a_i),
    .op_b     (op_b_i),
    .sgn      (sign_mode_e'(signed_i)),
    .acc_en   (acc_en_i),
    .any_vld  (any_vld),
    .fin_vld  (fin_vld),
    .fin_acc  (fin_acc),
    .fin_prod (fin_prod)
  );

  mac_acc #(.RES_W(RES_W)) acc_i (
    .clk      (clk),
    .rst      (rst),
    .fin_vld  (fin_vld),
    .fin_acc  (fin_acc),
    .clear    (clear_i),
    .fin_prod (fin_prod),
    .done     (done_o),
    .result   (result_o),
    .acc      (acc_o),
    .zero     (zero_o),
    .neg      (neg_o)
  );
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int LAT   = 2,
  parameter int RES_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             clear_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [RES_W-1:0] result_o,
  input logic [RES_W-1:0] acc_o,
  input logic             zero_o,
  input logic             neg_o
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LAT_C = CW'(LAT);

  // Cycles since the accepted start, counted from the port view.
  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (start_i && !busy_o)      cnt <= CW'(1);
    else if (cnt != '0 && cnt < LAT_C) cnt <= cnt + 1'b1;
    else                              cnt <= '0;
  end

  // R3
  done_at_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAT_C) == done_o);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R4
  busy_span_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o == (cnt != '0));

  // R5
  err_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o) |=> err_o);

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(start_i && busy_o) |=> !err_o);

  // R8
  clear_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (clear_i && !busy_o) |=> (acc_o == '0));

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !clear_i) |=> $stable(acc_o));

  // R10
  flag_match_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((zero_o == (result_o == '0)) && (neg_o == result_o[RES_W-1])));
endmodule

bind mac_unit mac_unit_chk #(.LAT(LAT), .RES_W(RES_W)) mac_chk_i (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .clear_i  (clear_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .result_o (result_o),
  .acc_o    (acc_o),
  .zero_o   (zero_o),
  .neg_o    (neg_o)
);

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam bit LONG_LAT   = 1'b0;
  localparam int LAT        = LONG_LAT ? 5 : 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, signed_i = 1'b0, acc_en_i = 1'b0, clear_i = 1'b0;
  logic [31:0] op_a_i = '0, op_b_i = '0;
  logic        busy_o, done_o, err_o, zero_o, neg_o;
  logic [63:0] result_o, acc_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [63:0] acc_model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_unit #(.OP_W(32), .LONG_LAT(LONG_LAT)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .signed_i(signed_i),
    .acc_en_i(acc_en_i), .clear_i(clear_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .result_o(result_o),
    .acc_o(acc_o), .zero_o(zero_o), .neg_o(neg_o)
  );

  function automatic logic [63:0] ref_mul(logic [31:0] a, logic [31:0] b, logic sgn);
    longint sa, sb;
    if (sgn) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // One operation; optional clear in the cycle before done.
  task automatic run_op(logic [31:0] a, logic [31:0] b, logic sgn, logic acc,
                        logic clr_last, string tag);
    logic [63:0] p, exp_res;
    p = ref_mul(a, b, sgn);
    @(negedge clk);
    start_i = 1'b1; op_a_i = a; op_b_i = b; signed_i = sgn; acc_en_i = acc;
    @(negedge clk);
    start_i = 1'b0;
    chk({tag, " R4 busy after start"}, 64'(busy_o), 64'd1);
    chk({tag, " R3 no early done"}, 64'(done_o), 64'd0);
    for (int i = 1; i < LAT - 1; i++) @(negedge clk);
    clear_i = clr_last;
    @(negedge clk);
    clear_i = 1'b0;
    if (clr_last) acc_model = acc ? p : 64'd0;
    else if (acc) acc_model = acc_model + p;
    exp_res = acc ? acc_model : p;
    chk({tag, " R3 done"}, 64'(done_o), 64'd1);
    chk({tag, " R1 R2 R6 result"}, result_o, exp_res);
    chk({tag, " R6 R7 R9 acc"}, acc_o, acc_model);
    chk({tag, " R10 zero"}, 64'(zero_o), 64'(exp_res == 64'd0));
    chk({tag, " R10 neg"}, 64'(neg_o), 64'(exp_res[63]));
    @(negedge clk);
    chk({tag, " R3 single done"}, 64'(done_o), 64'd0);
    chk({tag, " R4 idle after done"}, 64'(busy_o), 64'd0);
  endtask

  task automatic ignored_start_test();
    logic [63:0] p;
    p = ref_mul(32'd7, 32'd9, 1'b0);
    @(negedge clk);
    start_i = 1'b1; op_a_i = 32'd7; op_b_i = 32'd9; signed_i = 1'b0; acc_en_i = 1'b0;
    @(negedge clk);
    op_a_i = 32'hDEAD_BEEF; op_b_i = 32'h1234_5678; acc_en_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; acc_en_i = 1'b0;
    chk("R5 err strobe", 64'(err_o), 64'd1);
    for (int i = 2; i < LAT; i++) @(negedge clk);
    chk("R5 done of first op", 64'(done_o), 64'd1);
    chk("R5 result of first op", result_o, p);
    chk("R5 acc untouched", acc_o, acc_model);
    @(negedge clk);
    chk("R5 err single", 64'(err_o), 64'd0);
    chk("R5 no second done", 64'(done_o), 64'd0);
    repeat (LAT + 1) begin
      @(negedge clk);
      chk("R5 no late done", 64'(done_o), 64'd0);
    end
    chk("R5 acc still untouched", acc_o, acc_model);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 busy", 64'(busy_o), 64'd0);
    chk("R11 done", 64'(done_o), 64'd0);
    chk("R11 err", 64'(err_o), 64'd0);
    chk("R11 result", result_o, 64'd0);
    chk("R11 acc", acc_o, 64'd0);
    chk("R11 flags", 64'({zero_o, neg_o}), 64'd0);

    // Corner operands in both modes.
    run_op(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, "R1 min*min");
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 1'b0, "R2 min*min");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R1 ones*ones");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, "R2 ones*ones");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, "R2 min*m1");
    run_op(32'hFFFF_FFFF, 32'd5,         1'b1, 1'b0, 1'b0, "R2 R10 negative");
    run_op(32'd0,         32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, "R10 zero");

    // Accumulate with wrap modulo 2^64.
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, "R6 acc first");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, "R6 acc wrap");
    chk("R6 wrap value", acc_o, 64'hFFFF_FFFC_0000_0002);
    run_op(32'd3, 32'd4, 1'b0, 1'b0, 1'b0, "R7 plain op");

    // Clear while idle.
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
    acc_model = '0;
    chk("R8 clear idle", acc_o, 64'd0);

    // Clear against a finishing accumulate.
    run_op(32'd100, 32'd100, 1'b0, 1'b1, 1'b0, "R6 acc seed");
    run_op(32'hFFFF_FFF0, 32'd3, 1'b1, 1'b1, 1'b1, "R9 clear vs acc");
    chk("R9 acc is lone product", acc_o, 64'hFFFF_FFFF_FFFF_FFD0);
    run_op(32'd6, 32'd6, 1'b0, 1'b1, 1'b0, "R9 acc continues");

    ignored_start_test();

    // Random mix.
    for (int n = 0; n < 60; n++) begin
      logic [31:0] ra, rb;
      logic rs, rc;
      ra = $urandom(); rb = $urandom();
      if (n % 8 == 0) ra = {ra[31], 31'h0};
      rs = 1'($urandom()); rc = 1'($urandom());
      run_op(ra, rb, rs, rc, ($urandom() % 10) == 0, "R1 R2 R6 random");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule